// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the status and control word of a floating-point unit, placed on a processor's register bus. It holds a rounding-mode field, a trap-enable field and a group of condition bits, all written through a fixed mask. It keeps five sticky exception flags that the arithmetic datapath sets as it runs. It also drives the active rounding control that the datapath uses.

A write stores the masked word. It reloads the sticky flags from the trap-enable field of the written value. It recodes the rounding control only if the rounding field of the written value differs from the one already stored. Rounding codes outside the supported set leave the active control as it was and raise a one-cycle error pulse. A read is combinational: it returns the stored word with the live sticky flags merged into their own bit range. The arithmetic itself is not part of this block.

Top module: `fpscr_top`

## Requirements
- R1: After synchronous reset, `rd_data` is 0, `round_mode` is 0 (nearest-even) and `round_err` is 0.
- R2: A write (`wr_en` high at a clock edge) stores only bits 2:0 (rounding code), 9:5 (trap enables) and 31:28 (condition bits) of `wr_data`. Bits 4:3 and 27:15 always read 0, and bits 14:10 never take their value from `wr_data[14:10]`.
- R3: `rd_data` equals the stored masked word ORed with the sticky flags placed at bits 14:10, and it reflects a write from the cycle after the write edge.
- R4: In a cycle without a write, each `exc_set` bit ORs into its sticky flag, and a flag stays set until the next write. Flag order is: bit 0 invalid (read bit 10), bit 1 divide-by-zero (bit 11), bit 2 overflow (bit 12), bit 3 underflow (bit 13), bit 4 inexact (bit 14).
- R5: A write loads sticky flag i from `wr_data[5+i]`. Any `exc_set` in the same cycle is ignored.
- R6: A write whose rounding code (`wr_data[2:0]`) differs from the stored code and is 0..3 sets `round_mode` to that code from the next cycle: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R7: A write whose rounding code equals the stored code leaves `round_mode` unchanged and gives no error, even when the stored code is an unsupported one.
- R8: A write with a changed rounding code of 4..7 leaves `round_mode` unchanged. It sets `round_err` high for exactly the cycle after that write, while the code is still stored and read back.
- R9: Without a write, `round_mode` holds its value and `round_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| exc_set | input | 5 | Exception-set pulses from the datapath |
| rd_data | output | 32 | Read data: stored word merged with the sticky flags |
| round_mode | output | 2 | Active rounding control |
| round_err | output | 1 | One-cycle pulse after an unsupported rounding code is written |

## Verification
Two functions can fall in the same cycle: a register write and the datapath's exception-set pulses. Both try to drive the sticky flags, and the write must win. The bench provokes the clash with directed writes that carry a trap pattern unlike the asserted `exc_set` bits, and with long random runs in which both strobes are often active together. Each cycle, the read value is judged against a behavioural model that gives the write precedence. A second overlap is an unsupported rounding code written while the mode is held; it is checked by writing the same bad code twice in a row and then a valid one.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;

    localparam int WORD_W   = 32;
    localparam int RND_W    = 3;
    localparam int MODE_W   = 2;
    localparam int EXC_N    = 5;
    localparam int COND_W   = 4;

    localparam int RND_LSB  = 0;
    localparam int TRAP_LSB = 5;
    localparam int FLAG_LSB = 10;
    localparam int COND_LSB = 28;

    localparam int NUM_SUPPORTED = 4;

    typedef enum logic [MODE_W-1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS     = 2'd2,
        RND_NEG     = 2'd3
    } round_t;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [EXC_N-1:0]  trap;
        logic [RND_W-1:0]  rnd;
    } ctrl_fields_t;

    function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int width);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < width; i++) begin
            m[lsb+i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] writable_mask();
        return field_mask(RND_LSB, RND_W) | field_mask(TRAP_LSB, EXC_N)
             | field_mask(COND_LSB, COND_W);
    endfunction

    function automatic logic code_supported(input logic [RND_W-1:0] code);
        return int'(code) < NUM_SUPPORTED;
    endfunction

    function automatic round_t code_to_mode(input logic [RND_W-1:0] code);
        round_t m;
        case (code)
            3'd0:    m = RND_NEAREST;
            3'd1:    m = RND_ZERO;
            3'd2:    m = RND_POS;
            3'd3:    m = RND_NEG;
            default: m = RND_NEAREST;
        endcase
        return m;
    endfunction

    function automatic ctrl_fields_t unpack_word(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.rnd  = w[RND_LSB +: RND_W];
        f.trap = w[TRAP_LSB +: EXC_N];
        f.cond = w[COND_LSB +: COND_W];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input ctrl_fields_t f,
                                                   input logic [EXC_N-1:0] flags);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RND_LSB +: RND_W]   = f.rnd;
        w[TRAP_LSB +: EXC_N]  = f.trap;
        w[COND_LSB +: COND_W] = f.cond;
        w[FLAG_LSB +: EXC_N]  = flags;
        return w;
    endfunction

endpackage

// File: rtl/fpscr_field_store.sv
module fpscr_field_store
    import fpscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_fields_t      fields
);

    localparam logic [WORD_W-1:0] WMASK = writable_mask();

    ctrl_fields_t fields_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (wr_en) begin
            fields_q <= unpack_word(wr_data & WMASK);
        end
    end

    assign fields = fields_q;

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(fields_q)) else $error("store changed without write"); // R2

endmodule

// File: rtl/fpscr_round_ctl.sv
module fpscr_round_ctl
    import fpscr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RND_W-1:0] new_code,
    input  logic [RND_W-1:0] old_code,
    output round_t           mode,
    output logic             err
);

    round_t mode_q;
    logic   err_q;
    logic   changed;
    logic   legal;

    always_comb begin
        changed = wr_en && (new_code != old_code);
        legal   = code_supported(new_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RND_NEAREST;
            err_q  <= 1'b0;
        end else begin
            err_q <= changed && !legal;
            if (changed && legal) begin
                mode_q <= code_to_mode(new_code);
            end
        end
    end

    assign mode = mode_q;
    assign err  = err_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(mode_q)) else $error("mode moved without write"); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> ($past(wr_en) && $past(new_code) >= 3'd4)) else $error("spurious error"); // R8
    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(mode_q)) else $error("mode moved on bad code"); // R8
    AST_SAME_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && new_code == old_code) |=> (!err_q && $stable(mode_q))) else $error("same code acted"); // R7

endmodule

// File: rtl/fpscr_sticky.sv
module fpscr_sticky
    import fpscr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [EXC_N-1:0] seed,
    input  logic [EXC_N-1:0] exc_set,
    output logic [EXC_N-1:0] flags
);

    logic [EXC_N-1:0] flags_q;

    for (genvar i = 0; i < EXC_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (wr_en) begin
                flags_q[i] <= seed[i];
            end else if (exc_set[i]) begin
                flags_q[i] <= 1'b1;
            end
        end
    end

    assign flags = flags_q;

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ((flags_q & $past(flags_q)) == $past(flags_q))) else $error("flag cleared"); // R4
    AST_WRITE_SEED: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> (flags_q == $past(seed))) else $error("seed not taken"); // R5

endmodule

// File: rtl/fpscr_top.sv
module fpscr_top
    import fpscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [4:0]        exc_set,
    output logic [31:0]       rd_data,
    output logic [1:0]        round_mode,
    output logic              round_err
);

    ctrl_fields_t     fields;
    logic [EXC_N-1:0] flags;
    round_t           mode;

    fpscr_field_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fields  (fields)
    );

    fpscr_round_ctl u_round (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .new_code (wr_data[RND_LSB +: RND_W]),
        .old_code (fields.rnd),
        .mode     (mode),
        .err      (round_err)
    );

    fpscr_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .seed    (wr_data[TRAP_LSB +: EXC_N]),
        .exc_set (exc_set),
        .flags   (flags)
    );

    assign rd_data    = pack_word(fields, flags);
    assign round_mode = mode;

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[4:3] == 2'b00) && (rd_data[27:15] == '0)) else $error("reserved bits set"); // R2
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[31:28] == $past(wr_data[31:28]) && rd_data[9:0] == ($past(wr_data[9:0]) & 10'h3E7))) else $error("read mismatch"); // R3

endmodule

// File: tb/fpscr_top_bench.sv
`timescale 1ns/1ps
module fpscr_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  exc_set = '0;
    logic [31:0] rd_data;
    logic [1:0]  round_mode;
    logic        round_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string tag = "R1";

    // reference state
    logic [31:0] m_store;
    logic [4:0]  m_flags;
    logic [1:0]  m_mode;
    logic        m_err;

    localparam logic [31:0] MASK = 32'hF000_03E7;

    always #2.5 clk = ~clk;

    fpscr_top u_fpscr_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .exc_set(exc_set), .rd_data(rd_data), .round_mode(round_mode),
        .round_err(round_err)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_store <= '0; m_flags <= '0; m_mode <= 2'd0; m_err <= 1'b0;
        end else begin
            m_err <= 1'b0;
            if (wr_en) begin
                m_store <= wr_data & MASK;
                m_flags <= wr_data[9:5];
                if (wr_data[2:0] != m_store[2:0]) begin
                    if (wr_data[2:0] < 3'd4) m_mode <= wr_data[1:0];
                    else m_err <= 1'b1;
                end
            end else begin
                m_flags <= m_flags | exc_set;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(tag, "rd_data", rd_data, m_store | ({27'd0, m_flags} << 10));
            check(tag, "round_mode", {30'd0, round_mode}, {30'd0, m_mode});
            check(tag, "round_err", {31'd0, round_err}, {31'd0, m_err});
        end
    end

    task automatic step(input logic we, input logic [31:0] d, input logic [4:0] e);
        @(negedge clk);
        wr_en = we; wr_data = d; exc_set = e;
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 5'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        @(negedge clk);
        check("R1", "reset rd_data", rd_data, 32'h0);
        check("R1", "reset mode", {30'd0, round_mode}, 32'h0);
        check("R1", "reset err", {31'd0, round_err}, 32'h0);

        tag = "R2";
        step(1'b1, 32'hFFFF_FFFF, 5'h0);
        idle();
        check("R2", "all-ones masked", rd_data, 32'hF000_7FE7);
        step(1'b1, 32'h0FFF_FC18, 5'h0);
        idle();
        check("R2", "unwritable bits", rd_data, 32'h0000_0000);

        tag = "R4";
        step(1'b0, 32'h0, 5'b00001);
        step(1'b0, 32'h0, 5'b10000);
        idle();
        check("R4", "sticky accumulate", rd_data, 32'h0000_4400);
        repeat (3) idle();
        check("R4", "sticky held", rd_data, 32'h0000_4400);

        tag = "R5";
        step(1'b1, 32'h0000_0140, 5'b11111);
        idle();
        check("R5", "seed beats exc_set", rd_data, 32'h0000_2940);

        tag = "R3";
        step(1'b1, 32'hA000_0000, 5'h0);
        step(1'b0, 32'h0, 5'b00100);
        idle();
        check("R3", "merge", rd_data, 32'hA000_1000);

        tag = "R6";
        step(1'b1, 32'h0000_0002, 5'h0);
        idle();
        check("R6", "mode up", {30'd0, round_mode}, 32'd2);
        step(1'b1, 32'h0000_0003, 5'h0);
        idle();
        check("R6", "mode down", {30'd0, round_mode}, 32'd3);
        step(1'b1, 32'h0000_0001, 5'h0);
        idle();
        check("R6", "mode zero", {30'd0, round_mode}, 32'd1);

        tag = "R8";
        step(1'b1, 32'h0000_0005, 5'h0);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        check("R8", "err pulse", {31'd0, round_err}, 32'd1);
        check("R8", "mode kept", {30'd0, round_mode}, 32'd1);
        check("R8", "code stored", rd_data, 32'h0000_0005);
        @(negedge clk);
        check("R8", "err one cycle", {31'd0, round_err}, 32'd0);

        tag = "R7";
        step(1'b1, 32'h0000_0005, 5'h0);
        idle();
        check("R7", "same bad code no err", {31'd0, round_err}, 32'd0);
        step(1'b1, 32'h0000_0001, 5'h0);
        idle();
        check("R7", "mode after recode", {30'd0, round_mode}, 32'd1);
        step(1'b1, 32'h0000_0001, 5'h0);
        idle();
        check("R7", "same code", {30'd0, round_mode}, 32'd1);

        tag = "R9";
        repeat (4) step(1'b0, 32'hFFFF_FFFF, 5'h0);
        idle();
        check("R9", "mode idle", {30'd0, round_mode}, 32'd1);

        tag = "R5";
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 3) == 0, $urandom, 5'($urandom));
        end
        idle();
        idle();
        finish_run();
    end

endmodule